// File: doc/BRIEF.md
# Radio Servo Bus Frame Transmitter

This block sends a fixed 25-byte control frame on one serial output line. Sixteen 11-bit channel values, two on/off auxiliary channels, a frame-lost bit and a failsafe bit arrive on parallel inputs. The block packs them into the frame and puts them on the line as characters of twelve bit times, at 100 kbit/s. The line is inverted with respect to an ordinary UART line, so it rests low when idle.

A frame starts on a fixed period of bit times. A mode input picks the slow period (1400 bit times, 14 ms) or the fast period (700 bit times, 7 ms). All inputs are copied into a shadow register at the moment a frame begins, so a frame always carries one consistent snapshot. A one-cycle pulse marks the end of each frame. The bit timer divides the system clock by a parameter equal to the clock frequency over 100000.

Top module: `srvbus_tx`

## Requirements
- R1: While reset is high, and in every bit slot outside a frame, `txLine` is 0 and `frameDone` is 0 except for its pulse. Outside a frame the line is 0, which is the inverted idle level.
- R2: Every bit slot lasts exactly `BIT_DIV` clock cycles. `txLine` changes only at slot boundaries.
- R3: Each character takes 12 slots. The line carries the inverse of the logic bit in each slot. The logic bits are, in order: a start bit of 0 (line 1), the eight data bits with bit 7 first, a parity bit, and two stop bits of 1 (line 0). The parity bit is 1 when the data byte holds an odd number of ones.
- R4: A frame is 25 characters. Byte 0 is 0xF0 and byte 24 is 0x00. Bytes 1 to 22 come from a 176-bit stream. Channel i (0..15) bit b sits at stream bit 11*i+b. Data byte k bit j is stream bit 8*(k-1)+j.
- R5: Byte 23 holds the flags. Bit 7 is `auxCh17`, bit 6 is `auxCh18`, bit 5 is `frameLost`, bit 4 is `failsafe`, and bits 3 to 0 are 0.
- R6: `frameDone` is high for exactly one cycle. That cycle is the first clock cycle after the last stop bit of byte 24 ends.
- R7: Frames start `SLOW_BITS` bit times apart when `fastMode` was 0 at the start of the earlier frame, and `FAST_BITS` apart when it was 1. `fastMode` is sampled only when a frame starts.
- R8: Channel and flag inputs are sampled only when a frame starts. Changes made during a frame do not appear in that frame.
- R9: The first frame's start bit appears `BIT_DIV` clock cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fastMode | input | 1 | 1 selects the fast frame period, 0 the slow one |
| chanIn | input | 16x11 | Proportional channel values, index 0 is channel 1 |
| auxCh17 | input | 1 | Auxiliary on/off channel 17 |
| auxCh18 | input | 1 | Auxiliary on/off channel 18 |
| frameLost | input | 1 | Frame-lost status bit |
| failsafe | input | 1 | Failsafe-active status bit |
| txLine | output | 1 | Inverted serial output line |
| frameDone | output | 1 | One-cycle pulse after each frame |

## Verification
Channel sets with all zeros and all ones show that every data slot is driven and that parity follows the byte. Arithmetic ramps with steps of 1, 128 and 0x555 put different bits at each 11-bit/8-bit boundary, which exposes any wrong packing offset or bit order. Each frame uses a different single flag bit, so a swapped flag position shows up. Mid-frame, the inputs and the mode are inverted: a mismatch in the later data slots or in the measured period shows that sampling leaks outside the frame boundary.

// File: rtl/srvbus_pkg.sv
package srvbus_pkg;
  localparam int NUM_CH      = 16;
  localparam int CH_W        = 11;
  localparam int STREAM_W    = NUM_CH * CH_W;
  localparam int DATA_BYTES  = STREAM_W / 8;
  localparam int FRAME_BYTES = DATA_BYTES + 3;
  localparam int CHAR_BITS   = 12;
  localparam int FRAME_BITS  = FRAME_BYTES * CHAR_BITS;
  localparam int SEL_W       = $clog2(FRAME_BYTES);
  localparam int BITCNT_W    = $clog2(CHAR_BITS);
  localparam logic [7:0] HEADER  = 8'hF0;
  localparam logic [7:0] TRAILER = 8'h00;

  typedef struct packed {
    logic             load;
    logic             startChar;
    logic             shiftBit;
    logic             goIdle;
    logic [SEL_W-1:0] byteSel;
  } txStrobe_t;
endpackage

// File: rtl/srvbus_ctrl.sv
module srvbus_ctrl
  import srvbus_pkg::*;
#(
  parameter int BIT_DIV   = 2000,
  parameter int SLOW_BITS = 1400,
  parameter int FAST_BITS = 700
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      fastMode,
  output txStrobe_t stb,
  output logic      frameDone
);
  localparam int MAX_PER = (SLOW_BITS > FAST_BITS) ? SLOW_BITS : FAST_BITS;
  localparam int DIV_W   = $clog2(BIT_DIV);
  localparam int PER_W   = $clog2(MAX_PER);

  logic [DIV_W-1:0]    divCnt;
  logic [PER_W-1:0]    perCnt;
  logic [PER_W-1:0]    perLast;
  logic [BITCNT_W-1:0] bitCnt;
  logic [SEL_W-1:0]    byteCnt;
  logic                modeSh;
  logic                inFrame;
  logic                tick;
  logic                frameStart;
  logic                charEnd;
  logic                lastChar;

  assign tick       = (divCnt == DIV_W'(BIT_DIV - 1));
  assign perLast    = modeSh ? PER_W'(FAST_BITS - 1) : PER_W'(SLOW_BITS - 1);
  assign frameStart = tick && (perCnt == perLast);
  assign charEnd    = inFrame && (bitCnt == BITCNT_W'(CHAR_BITS - 1));
  assign lastChar   = (byteCnt == SEL_W'(FRAME_BYTES - 1));

  always_comb begin
    stb.load      = frameStart;
    stb.startChar = frameStart || (tick && charEnd && !lastChar);
    stb.shiftBit  = tick && inFrame && !charEnd;
    stb.goIdle    = tick && charEnd && lastChar && !frameStart;
    stb.byteSel   = frameStart ? '0 : SEL_W'(byteCnt + SEL_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      divCnt    <= '0;
      perCnt    <= PER_W'(SLOW_BITS - 1);
      modeSh    <= 1'b0;
      inFrame   <= 1'b0;
      bitCnt    <= '0;
      byteCnt   <= '0;
      frameDone <= 1'b0;
    end else begin
      divCnt    <= tick ? '0 : DIV_W'(divCnt + DIV_W'(1));
      frameDone <= tick && charEnd && lastChar;
      if (tick) begin
        perCnt <= frameStart ? '0 : PER_W'(perCnt + PER_W'(1));
        if (frameStart) begin
          modeSh  <= fastMode;
          inFrame <= 1'b1;
          bitCnt  <= '0;
          byteCnt <= '0;
        end else if (inFrame) begin
          if (charEnd) begin
            bitCnt <= '0;
            if (lastChar) inFrame <= 1'b0;
            else          byteCnt <= SEL_W'(byteCnt + SEL_W'(1));
          end else begin
            bitCnt <= BITCNT_W'(bitCnt + BITCNT_W'(1));
          end
        end
      end
    end
  end
endmodule

// File: rtl/srvbus_dp.sv
module srvbus_dp
  import srvbus_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  txStrobe_t                      stb,
  input  logic [NUM_CH-1:0][CH_W-1:0]    chanIn,
  input  logic [3:0]                     flagIn,
  output logic                           txLine
);
  localparam int SH_W = CHAR_BITS - 1;

  logic [STREAM_W-1:0] packIn;
  logic [STREAM_W-1:0] packSh;
  logic [3:0]          flagSh;
  logic [7:0]          charByte;
  logic [SH_W-1:0]     shiftReg;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_pack
    assign packIn[i*CH_W +: CH_W] = chanIn[i];
  end

  always_comb begin
    charByte = TRAILER;
    if (stb.byteSel == '0)
      charByte = HEADER;
    else if (int'(stb.byteSel) <= DATA_BYTES)
      charByte = 8'(packSh >> (8 * (int'(stb.byteSel) - 1)));
    else if (int'(stb.byteSel) == DATA_BYTES + 1)
      charByte = {flagSh, 4'b0000};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      packSh   <= '0;
      flagSh   <= '0;
      shiftReg <= '1;
      txLine   <= 1'b0;
    end else begin
      if (stb.load) begin
        packSh <= packIn;
        flagSh <= flagIn;
      end
      if (stb.startChar) begin
        txLine   <= 1'b1;
        shiftReg <= {charByte, ^charByte, 2'b11};
      end else if (stb.shiftBit) begin
        txLine   <= ~shiftReg[SH_W-1];
        shiftReg <= {shiftReg[SH_W-2:0], 1'b1};
      end else if (stb.goIdle) begin
        txLine <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/srvbus_tx.sv
module srvbus_tx
  import srvbus_pkg::*;
#(
  parameter int BIT_DIV   = 2000,
  parameter int SLOW_BITS = 1400,
  parameter int FAST_BITS = 700
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fastMode,
  input  logic [NUM_CH-1:0][CH_W-1:0] chanIn,
  input  logic                        auxCh17,
  input  logic                        auxCh18,
  input  logic                        frameLost,
  input  logic                        failsafe,
  output logic                        txLine,
  output logic                        frameDone
);
  txStrobe_t stb;

  srvbus_ctrl #(
    .BIT_DIV  (BIT_DIV),
    .SLOW_BITS(SLOW_BITS),
    .FAST_BITS(FAST_BITS)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .fastMode (fastMode),
    .stb      (stb),
    .frameDone(frameDone)
  );

  srvbus_dp u_dp (
    .clk   (clk),
    .rst   (rst),
    .stb   (stb),
    .chanIn(chanIn),
    .flagIn({auxCh17, auxCh18, frameLost, failsafe}),
    .txLine(txLine)
  );
endmodule

// File: rtl/srvbus_chk.sv
module srvbus_chk (
  input logic clk,
  input logic rst,
  input logic startChar,
  input logic shiftBit,
  input logic goIdle,
  input logic txLine,
  input logic frameDone
);
  // R2
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !(startChar || shiftBit || goIdle) |=> $stable(txLine));

  // R3
  start_bit_level_chk: assert property (@(posedge clk) disable iff (rst)
    startChar |=> txLine);

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    frameDone |=> !frameDone);

  // R1
  idle_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    goIdle |=> (!txLine && frameDone));
endmodule

bind srvbus_tx srvbus_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .startChar(stb.startChar),
  .shiftBit (stb.shiftBit),
  .goIdle   (stb.goIdle),
  .txLine   (txLine),
  .frameDone(frameDone)
);

// File: tb/srvbus_tx_bench.sv
`timescale 1ns/1ps
module srvbus_tx_bench;
  localparam int D    = 4;
  localparam int SLOW = 400;
  localparam int FAST = 320;
  localparam int NV   = 6;
  // entry: {seed[10:0], step[10:0], flags{aux17,aux18,lost,failsafe}, mode}
  localparam logic [26:0] STIM [NV] = '{
    {11'd0,    11'd0,    4'b0000, 1'b0},
    {11'd2047, 11'd0,    4'b1111, 1'b1},
    {11'd1,    11'd128,  4'b1000, 1'b0},
    {11'd1024, 11'd1,    4'b0100, 1'b1},
    {11'h2AA,  11'h555,  4'b0010, 1'b1},
    {11'h7F0,  11'd37,   4'b0001, 1'b0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fastMode = 1'b0;
  logic [15:0][10:0] chanIn = '0;
  logic auxCh17 = 1'b0, auxCh18 = 1'b0, frameLost = 1'b0, failsafe = 1'b0;
  logic txLine, frameDone;
  logic expLine [300];
  int cyc = 0;
  int nChecks = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  srvbus_tx #(.BIT_DIV(D), .SLOW_BITS(SLOW), .FAST_BITS(FAST)) u_srvbus_tx (
    .clk(clk), .rst(rst), .fastMode(fastMode), .chanIn(chanIn),
    .auxCh17(auxCh17), .auxCh18(auxCh18), .frameLost(frameLost),
    .failsafe(failsafe), .txLine(txLine), .frameDone(frameDone)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic applyStim(input logic [26:0] s);
    for (int i = 0; i < 16; i++) chanIn[i] = 11'(s[26:16] + 11'(i) * s[15:5]);
    {auxCh17, auxCh18, frameLost, failsafe} = s[4:1];
    fastMode = s[0];
  endtask

  task automatic buildExp(input logic [26:0] s);
    logic [175:0] stream;
    logic [7:0] by;
    logic [10:0] ch;
    for (int i = 0; i < 16; i++) begin
      ch = 11'(s[26:16] + 11'(i) * s[15:5]);
      for (int b = 0; b < 11; b++) stream[i*11 + b] = ch[b];
    end
    for (int k = 0; k < 25; k++) begin
      if (k == 0) by = 8'hF0;
      else if (k <= 22) by = stream[(k-1)*8 +: 8];
      else if (k == 23) by = {s[4:1], 4'b0000};
      else by = 8'h00;
      expLine[k*12] = 1'b1;
      for (int j = 0; j < 8; j++) expLine[k*12 + 1 + j] = ~by[7-j];
      expLine[k*12 + 9]  = ~(^by);
      expLine[k*12 + 10] = 1'b0;
      expLine[k*12 + 11] = 1'b0;
    end
  endtask

  task automatic waitStart(output int t);
    @(negedge clk);
    while (!txLine) @(negedge clk);
    t = cyc;
  endtask

  // Entered at the negedge of the first cycle of slot 0.
  task automatic checkFrame(input int v);
    int badHold = 0, badFrame = 0, badData = 0, badFlag = 0, badLate = 0;
    logic first;
    logic samp;
    for (int k = 0; k < 300; k++) begin
      for (int j = 0; j < D; j++) begin
        if (k != 0 || j != 0) @(negedge clk);
        if (k == 100 && j == 0) begin
          chanIn = ~chanIn;
          {auxCh17, auxCh18, frameLost, failsafe} = ~{auxCh17, auxCh18, frameLost, failsafe};
          fastMode = ~fastMode;
        end
        if (j == 0) first = txLine;
        else if (txLine !== first) badHold++;
        if (j == D/2) begin
          samp = txLine;
          if (samp !== expLine[k]) begin
            if ((k % 12) == 0 || (k % 12) >= 9) badFrame++;
            else if (k / 12 == 23) badFlag++;
            else badData++;
            if (k >= 100 && (k / 12) >= 1 && (k / 12) <= 23) badLate++;
          end
        end
      end
    end
    check(badHold == 0, "R2", $sformatf("slot hold violations frame %0d", v), badHold, 0);
    check(badFrame == 0, "R3", $sformatf("start/parity/stop errors frame %0d", v), badFrame, 0);
    check(badData == 0, "R4", $sformatf("data bit errors frame %0d", v), badData, 0);
    check(badFlag == 0, "R5", $sformatf("flag bit errors frame %0d", v), badFlag, 0);
    check(badLate == 0, "R8", $sformatf("late-slot errors after input change frame %0d", v), badLate, 0);
    @(negedge clk);
    check(frameDone === 1'b1, "R6", $sformatf("done pulse after frame %0d", v), int'(frameDone), 1);
    check(txLine === 1'b0, "R1", $sformatf("idle level after frame %0d", v), int'(txLine), 0);
    @(negedge clk);
    check(frameDone === 1'b0, "R6", $sformatf("done width frame %0d", v), int'(frameDone), 0);
  endtask

  task automatic runAll();
    int t0, t1, tRel;
    applyStim(STIM[0]);
    repeat (3) @(negedge clk);
    check(txLine === 1'b0, "R1", "line during reset", int'(txLine), 0);
    check(frameDone === 1'b0, "R1", "done during reset", int'(frameDone), 0);
    rst = 1'b0;
    tRel = cyc;
    waitStart(t0);
    check(t0 - tRel == D, "R9", "first frame delay", t0 - tRel, D);
    for (int v = 0; v < NV; v++) begin
      buildExp(STIM[v]);
      checkFrame(v);
      applyStim(STIM[(v < NV-1) ? v+1 : v]);
      waitStart(t1);
      check(t1 - t0 == (STIM[v][0] ? FAST : SLOW) * D, "R7",
            $sformatf("frame period after frame %0d", v), t1 - t0,
            (STIM[v][0] ? FAST : SLOW) * D);
      t0 = t1;
    end
    // Directed: reset in mid-frame returns the line to idle (R1)
    repeat (5 * D) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(txLine === 1'b0, "R1", "line after mid-frame reset", int'(txLine), 0);
    repeat (3 * D) @(negedge clk);
    check(txLine === 1'b0, "R1", "line held low in reset", int'(txLine), 0);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        nChecks++;
        nErr++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule